// File: doc/BRIEF.md
# Address-Region Access Firewall

This block sits in front of a memory target and gives an allow or deny verdict for each request. Software programs up to `NREG` address windows through a small 32-bit register port. Each window has an inclusive start and end address, one permission mask for CPU initiators, read and write permission banks for all other initiators, and a rule on the 3-bit protection attribute of the request. A window takes part in the check only once its bit is set in a shared enable register, so software enables a window as the last step of programming it.

Every mask is changed through a pair of locations. A one written to the set location sets those bits, and a one written to the clear location clears them. When a request is rejected, the block raises a one-cycle event on the next clock edge. The event carries the address, the direction and the initiator ID, so that an error logger can record it. The verdict itself is combinational and is valid in the same cycle as the request.

The window count must be a power of two. The register address is `$clog2(NREG)+9` bits wide, and the byte offset of each register sits in bits [7:0].

Top module: `region_fw`

## Requirements
- R1: After reset, every window register, every mask and the enable register read back as zero.
- R2: Window r has its registers at r*0x100. The start address is at +0x00 and the end address at +0x04; both are plain writes. Each mask has a set location and a clear location 4 bytes apart: CPU mask at +0x10/+0x14, read bank b at +0x20+8b/+0x24+8b, write bank b at +0x40+8b/+0x44+8b, protection-enable at +0x60/+0x64, protection-value at +0x68/+0x6C. A set write ORs the data into the mask and a clear write removes the bits that are one in the data. A read at either location of a pair returns the current mask.
- R3: The enable register has its set location at NREG*0x100 and its clear location at NREG*0x100+4, with bit r for window r. A window that is not enabled has no effect on any verdict.
- R4: A request hits a window when start <= address <= end, with both bounds included.
- R5: For a request with the CPU flag set, the window grants a write if CPU mask bit c is set and a read if bit 4+c is set, where c is ID[1:0]. The non-CPU banks are not consulted.
- R6: For a request with the CPU flag clear, the window grants the request if bit ID%32 of the read or write bank ID/32 is set. IDs of 32*BANKS and above are never granted. The CPU mask is not consulted.
- R7: A read is granted only if ((prot XOR value[6:4]) AND enable[6:4]) is zero. A write uses bits [2:0] of the two masks in the same way.
- R8: A request that hits no enabled window is denied if any enabled window has its strict flag set for the request's direction, and allowed otherwise. The strict flag for reads is value bit 7 and for writes is value bit 3.
- R9: A request that hits at least one enabled window is allowed if any enabled hit window grants it, even when other hit windows do not.
- R10: A rejected valid request raises `deny_vld` for exactly one cycle, on the next clock edge, together with its address, direction and ID. No other request raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NREG)+9 | Register byte address for writes and readback |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the register at `cfg_addr` (combinational) |
| req_valid | input | 1 | A request is presented |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 1 | Initiator is a CPU |
| req_id | input | 8 | Initiator ID |
| req_prot | input | 3 | Protection attribute of the request |
| req_allow | output | 1 | Verdict for the current request |
| deny_vld | output | 1 | One-cycle rejection event |
| deny_addr | output | ADDR_W | Address of the rejected request |
| deny_write | output | 1 | Direction of the rejected request |
| deny_id | output | 8 | Initiator ID of the rejected request |

## Verification
The checker covers four things on every cycle. It ties each rejection event to the rejected request one cycle earlier, and checks that no event appears without one. It checks that the filter is fully open while no window is enabled. It checks that writes to the set and clear locations of the enable register reach the enable bits. The bench's scenarios are needed for everything that depends on programmed contents: the bounds of a window, the CPU and non-CPU permission maps across all 256 IDs, the protection match over all attribute values, the strict miss policy, overlapping windows, and mask readback after set and clear writes.

// File: rtl/fw_pkg.sv
package fw_pkg;

    localparam int FW_ID_W   = 8;
    localparam int FW_PROT_W = 3;

    // Byte offsets inside one window's register group
    localparam logic [7:0] OFF_START = 8'h00;
    localparam logic [7:0] OFF_END   = 8'h04;
    localparam logic [7:0] OFF_CPU   = 8'h10;
    localparam logic [7:0] OFF_RBANK = 8'h20;
    localparam logic [7:0] OFF_WBANK = 8'h40;
    localparam logic [7:0] OFF_PEN   = 8'h60;
    localparam logic [7:0] OFF_PVAL  = 8'h68;

    // Offsets inside the global group
    localparam logic [7:0] OFF_EN_SET = 8'h00;
    localparam logic [7:0] OFF_EN_CLR = 8'h04;

    typedef struct packed {
        logic                 write;
        logic                 cpu;
        logic [FW_ID_W-1:0]   id;
        logic [FW_PROT_W-1:0] prot;
    } req_attr_t;

    function automatic logic [7:0] sc8(input logic [7:0] cur, input logic [7:0] wd, input logic clr);
        return clr ? (cur & ~wd) : (cur | wd);
    endfunction

    function automatic logic [31:0] sc32(input logic [31:0] cur, input logic [31:0] wd, input logic clr);
        return clr ? (cur & ~wd) : (cur | wd);
    endfunction

    function automatic logic prot_ok(input logic [2:0] prot, input logic [2:0] en, input logic [2:0] val);
        return ((prot ^ val) & en) == 3'b000;
    endfunction

endpackage

// File: rtl/fw_region.sv
module fw_region
    import fw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BANKS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_off,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        rd_off,
    output logic [31:0]       rd_data,
    input  logic [ADDR_W-1:0] q_addr,
    input  req_attr_t         q_attr,
    output logic              hit,
    output logic              grant,
    output logic              strict_rd,
    output logic              strict_wr
);
    localparam int SEL_W = FW_ID_W - 5;

    logic [ADDR_W-1:0] start_q, end_q;
    logic [7:0]        cpu_q, pen_q, pval_q;
    logic [31:0]       rbank_q [BANKS];
    logic [31:0]       wbank_q [BANKS];

    logic       is_clr, low_ok;
    logic [7:0] wr_pair;
    assign is_clr  = wr_off[2];
    assign low_ok  = (wr_off[1:0] == 2'b00);
    assign wr_pair = {wr_off[7:3], 3'b000};

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            end_q   <= '0;
            cpu_q   <= '0;
            pen_q   <= '0;
            pval_q  <= '0;
            for (int b = 0; b < BANKS; b++) begin
                rbank_q[b] <= '0;
                wbank_q[b] <= '0;
            end
        end else if (wr_en && low_ok) begin
            if (wr_off == OFF_START) start_q <= wr_data[ADDR_W-1:0];
            if (wr_off == OFF_END)   end_q   <= wr_data[ADDR_W-1:0];
            if (wr_pair == OFF_CPU)  cpu_q   <= sc8(cpu_q, wr_data[7:0], is_clr);
            if (wr_pair == OFF_PEN)  pen_q   <= sc8(pen_q, wr_data[7:0], is_clr);
            if (wr_pair == OFF_PVAL) pval_q  <= sc8(pval_q, wr_data[7:0], is_clr);
            for (int b = 0; b < BANKS; b++) begin
                if (wr_pair == OFF_RBANK + 8'(8 * b)) rbank_q[b] <= sc32(rbank_q[b], wr_data, is_clr);
                if (wr_pair == OFF_WBANK + 8'(8 * b)) wbank_q[b] <= sc32(wbank_q[b], wr_data, is_clr);
            end
        end
    end

    // Readback: either location of a pair returns the mask
    logic [7:0] rd_pair;
    assign rd_pair = {rd_off[7:3], 3'b000};

    always_comb begin
        rd_data = '0;
        if (rd_off[1:0] == 2'b00) begin
            if (rd_off == OFF_START)      rd_data = 32'(start_q);
            else if (rd_off == OFF_END)   rd_data = 32'(end_q);
            else if (rd_pair == OFF_CPU)  rd_data = {24'b0, cpu_q};
            else if (rd_pair == OFF_PEN)  rd_data = {24'b0, pen_q};
            else if (rd_pair == OFF_PVAL) rd_data = {24'b0, pval_q};
            for (int b = 0; b < BANKS; b++) begin
                if (rd_pair == OFF_RBANK + 8'(8 * b)) rd_data = rbank_q[b];
                if (rd_pair == OFF_WBANK + 8'(8 * b)) rd_data = wbank_q[b];
            end
        end
    end

    // Request match
    logic [SEL_W-1:0] bank_sel;
    logic [4:0]       bit_sel;
    logic             nc_rd, nc_wr, perm, pok;
    assign bank_sel = q_attr.id[FW_ID_W-1:5];
    assign bit_sel  = q_attr.id[4:0];

    always_comb begin
        nc_rd = 1'b0;
        nc_wr = 1'b0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_sel == SEL_W'(b)) begin
                nc_rd = rbank_q[b][bit_sel];
                nc_wr = wbank_q[b][bit_sel];
            end
        end
    end

    assign perm = q_attr.cpu ? cpu_q[{~q_attr.write, q_attr.id[1:0]}]
                             : (q_attr.write ? nc_wr : nc_rd);
    assign pok  = q_attr.write ? prot_ok(q_attr.prot, pen_q[2:0], pval_q[2:0])
                               : prot_ok(q_attr.prot, pen_q[6:4], pval_q[6:4]);

    assign hit       = (q_addr >= start_q) && (q_addr <= end_q);
    assign grant     = hit && perm && pok;
    assign strict_rd = pval_q[7];
    assign strict_wr = pval_q[3];

endmodule

// File: rtl/fw_verdict.sv
module fw_verdict #(
    parameter int NREG = 8
) (
    input  logic [NREG-1:0] en,
    input  logic [NREG-1:0] hit,
    input  logic [NREG-1:0] grant,
    input  logic [NREG-1:0] strict_rd,
    input  logic [NREG-1:0] strict_wr,
    input  logic            write,
    output logic            allow
);
    logic any_hit, any_grant, strict;

    assign any_hit   = |(hit & en);
    assign any_grant = |(grant & en);
    assign strict    = |(en & (write ? strict_wr : strict_rd));
    assign allow     = any_grant || (!any_hit && !strict);

endmodule

// File: rtl/region_fw.sv
module region_fw
    import fw_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int ADDR_W = 32,
    parameter int BANKS  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_wr,
    input  logic [$clog2(NREG)+8:0]   cfg_addr,
    input  logic [31:0]               cfg_wdata,
    output logic [31:0]               cfg_rdata,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_write,
    input  logic                      req_cpu,
    input  logic [7:0]                req_id,
    input  logic [2:0]                req_prot,
    output logic                      req_allow,
    output logic                      deny_vld,
    output logic [ADDR_W-1:0]         deny_addr,
    output logic                      deny_write,
    output logic [7:0]                deny_id
);
    localparam int RIDX_W = $clog2(NREG);

    logic              glob;
    logic [RIDX_W-1:0] ridx;
    logic [7:0]        off;
    assign glob = cfg_addr[RIDX_W+8];
    assign ridx = cfg_addr[RIDX_W+7:8];
    assign off  = cfg_addr[7:0];

    req_attr_t attr;
    assign attr = '{write: req_write, cpu: req_cpu, id: req_id, prot: req_prot};

    logic [NREG-1:0] en_q;
    logic [NREG-1:0] hit, grant, s_rd, s_wr;
    logic [31:0]     rgn_rd [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (cfg_wr && glob) begin
            if (off == OFF_EN_SET) en_q <= en_q | cfg_wdata[NREG-1:0];
            if (off == OFF_EN_CLR) en_q <= en_q & ~cfg_wdata[NREG-1:0];
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_rgn
        fw_region #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_rgn (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (cfg_wr && !glob && (ridx == RIDX_W'(r))),
            .wr_off    (off),
            .wr_data   (cfg_wdata),
            .rd_off    (off),
            .rd_data   (rgn_rd[r]),
            .q_addr    (req_addr),
            .q_attr    (attr),
            .hit       (hit[r]),
            .grant     (grant[r]),
            .strict_rd (s_rd[r]),
            .strict_wr (s_wr[r])
        );
    end

    always_comb begin
        if (glob) cfg_rdata = (off == OFF_EN_SET || off == OFF_EN_CLR) ? 32'(en_q) : 32'h0;
        else      cfg_rdata = rgn_rd[ridx];
    end

    fw_verdict #(.NREG(NREG)) u_verdict (
        .en        (en_q),
        .hit       (hit),
        .grant     (grant),
        .strict_rd (s_rd),
        .strict_wr (s_wr),
        .write     (req_write),
        .allow     (req_allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            deny_vld   <= 1'b0;
            deny_addr  <= '0;
            deny_write <= 1'b0;
            deny_id    <= '0;
        end else begin
            deny_vld <= req_valid && !req_allow;
            if (req_valid && !req_allow) begin
                deny_addr  <= req_addr;
                deny_write <= req_write;
                deny_id    <= req_id;
            end
        end
    end

endmodule

// File: rtl/region_fw_chk.sv
module region_fw_chk #(
    parameter int NREG   = 8,
    parameter int ADDR_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cfg_wr,
    input logic [$clog2(NREG)+8:0] cfg_addr,
    input logic [31:0]             cfg_wdata,
    input logic                    req_valid,
    input logic [ADDR_W-1:0]       req_addr,
    input logic                    req_write,
    input logic [7:0]              req_id,
    input logic                    req_allow,
    input logic                    deny_vld,
    input logic [ADDR_W-1:0]       deny_addr,
    input logic                    deny_write,
    input logic [7:0]              deny_id,
    input logic [NREG-1:0]         en_q
);
    localparam int RIDX_W = $clog2(NREG);
    localparam logic [RIDX_W+8:0] EN_SET = {1'b1, {RIDX_W{1'b0}}, 8'h00};
    localparam logic [RIDX_W+8:0] EN_CLR = {1'b1, {RIDX_W{1'b0}}, 8'h04};

    assert_deny_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_allow) |=> (deny_vld && deny_addr == $past(req_addr)
                                       && deny_write == $past(req_write) && deny_id == $past(req_id)));

    assert_deny_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
        deny_vld |-> $past(req_valid && !req_allow));

    assert_open_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && en_q == '0) |-> req_allow);

    assert_enable_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == EN_CLR && cfg_wdata[NREG-1:0] == '1) |=> (en_q == '0));

    assert_enable_set_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == EN_SET) |=>
            ((en_q & $past(cfg_wdata[NREG-1:0])) == $past(cfg_wdata[NREG-1:0])));

endmodule

bind region_fw region_fw_chk #(.NREG(NREG), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_id     (req_id),
    .req_allow  (req_allow),
    .deny_vld   (deny_vld),
    .deny_addr  (deny_addr),
    .deny_write (deny_write),
    .deny_id    (deny_id),
    .en_q       (en_q)
);

// File: tb/region_fw_tb.sv
`timescale 1ns/1ps
module region_fw_tb;
    localparam int NREG = 8;
    localparam int AW   = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_cpu = 1'b0;
    logic [7:0]  req_id = '0;
    logic [2:0]  req_prot = '0;
    logic        req_allow, deny_vld, deny_write;
    logic [31:0] deny_addr;
    logic [7:0]  deny_id;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    region_fw #(.NREG(NREG), .ADDR_W(AW), .BANKS(4)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_cpu(req_cpu),
        .req_id(req_id), .req_prot(req_prot), .req_allow(req_allow),
        .deny_vld(deny_vld), .deny_addr(deny_addr), .deny_write(deny_write),
        .deny_id(deny_id)
    );

    localparam logic [11:0] EN_SET = 12'h800;
    localparam logic [11:0] EN_CLR = 12'h804;

    function automatic logic [11:0] ra(input int r, input int o);
        return 12'(r * 256 + o);
    endfunction

    function automatic logic [31:0] rdm(input int b);
        return 32'(32'h9E3779B9 * 32'(b + 1));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(cfg_rdata === exp, tag, cfg_rdata, exp);
    endtask

    task automatic req_chk(input logic [31:0] a, input logic wr, input logic cpu,
                           input logic [7:0] id, input logic [2:0] pr,
                           input logic exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_cpu = cpu; req_id = id; req_prot = pr;
        #1;
        chk(req_allow === exp, tag, 32'(req_allow), 32'(exp));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        // R10: event one edge later, with the request's fields
        chk(deny_vld === !exp, {tag, " R10 pulse"}, 32'(deny_vld), 32'(!exp));
        if (!exp)
            chk(deny_addr === a && deny_write === wr && deny_id === id, {tag, " R10 fields"},
                deny_addr, a);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int r = 0; r < NREG; r++) begin
            cfg_read(ra(r, 'h00), 0, "R1 start");
            cfg_read(ra(r, 'h04), 0, "R1 end");
            cfg_read(ra(r, 'h10), 0, "R1 cpu");
            cfg_read(ra(r, 'h24), 0, "R1 rbank");
            cfg_read(ra(r, 'h60), 0, "R1 pen");
            cfg_read(ra(r, 'h6C), 0, "R1 pval");
        end
        cfg_read(EN_SET, 0, "R1 enable");

        // Window 0: CPU0 read+write, CPU2 read only
        cfg_write(ra(0, 'h00), 32'h1000);
        cfg_write(ra(0, 'h04), 32'h1FFF);
        cfg_write(ra(0, 'h10), 32'h51);
        cfg_read(ra(0, 'h04), 32'h1FFF, "R2 end readback");
        cfg_read(ra(0, 'h14), 32'h51, "R2 cpu readback");
        req_chk(32'h1800, 1, 1, 8'd1, 0, 1'b1, "R3 disabled window");
        cfg_write(EN_SET, 32'h1);
        cfg_read(EN_CLR, 32'h1, "R3 enable readback");
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 2; w++) begin
                automatic logic [7:0] m = 8'h51;
                req_chk(32'h1800, w[0], 1, 8'(c), 0, m[(w != 0 ? 0 : 4) + c], "R5 cpu map");
            end

        // R4: inclusive bounds, no strict
        req_chk(32'h0FFF, 0, 1, 8'd1, 0, 1'b1, "R4 below");
        req_chk(32'h1000, 0, 1, 8'd1, 0, 1'b0, "R4 start");
        req_chk(32'h1FFF, 0, 1, 8'd1, 0, 1'b0, "R4 end");
        req_chk(32'h2000, 0, 1, 8'd1, 0, 1'b1, "R4 above");
        req_chk(32'h1000, 0, 1, 8'd0, 0, 1'b1, "R4 start grant");

        // R8: strict miss policy per direction
        cfg_write(ra(0, 'h68), 32'h80);
        req_chk(32'h2000, 0, 1, 8'd1, 0, 1'b0, "R8 read strict");
        req_chk(32'h2000, 1, 1, 8'd1, 0, 1'b1, "R8 write lax");
        cfg_write(ra(0, 'h68), 32'h08);
        req_chk(32'h2000, 1, 1, 8'd1, 0, 1'b0, "R8 write strict");

        // Window 1: non-CPU banks
        cfg_write(ra(1, 'h00), 32'h4000);
        cfg_write(ra(1, 'h04), 32'h4FFF);
        for (int b = 0; b < 4; b++) begin
            cfg_write(ra(1, 'h20 + 8 * b), rdm(b));
            cfg_write(ra(1, 'h40 + 8 * b), ~rdm(b));
        end
        cfg_read(ra(1, 'h30), rdm(2), "R2 bank readback");
        cfg_write(EN_SET, 32'h2);
        for (int id = 0; id < 256; id++)
            for (int w = 0; w < 2; w++) begin
                automatic logic [31:0] m = (w != 0) ? ~rdm(id / 32) : rdm(id / 32);
                automatic logic e = (id < 128) ? m[id % 32] : 1'b0;
                req_chk(32'h4100, w[0], 0, 8'(id), 3'b101, e, "R6 bank map");
            end
        req_chk(32'h4100, 0, 1, 8'd0, 0, 1'b0, "R5 cpu ignores banks");
        req_chk(32'h1800, 0, 0, 8'd0, 0, 1'b0, "R6 noncpu ignores cpu mask");

        // Window 2: protection match
        cfg_write(ra(2, 'h00), 32'h6000);
        cfg_write(ra(2, 'h04), 32'h6FFF);
        cfg_write(ra(2, 'h10), 32'hFF);
        cfg_write(ra(2, 'h60), 32'h22);
        cfg_write(ra(2, 'h68), 32'h22);
        cfg_write(EN_SET, 32'h4);
        for (int p = 0; p < 8; p++)
            for (int w = 0; w < 2; w++)
                req_chk(32'h6000, w[0], 1, 8'd0, 3'(p), p[1], "R7 prot bit1");
        cfg_write(ra(2, 'h60), 32'h11);
        cfg_read(ra(2, 'h64), 32'h33, "R2 pen set merge");
        for (int p = 0; p < 8; p++)
            for (int w = 0; w < 2; w++)
                req_chk(32'h6000, w[0], 1, 8'd0, 3'(p), p[1] & ~p[0], "R7 prot bits1,0");

        // R2: clear all, then set/clear single bits
        cfg_write(ra(2, 'h14), 32'hFFFF_FFFF);
        cfg_read(ra(2, 'h10), 32'h0, "R2 clear all");
        req_chk(32'h6000, 0, 1, 8'd0, 3'b010, 1'b0, "R2 cleared deny");
        cfg_write(ra(2, 'h10), 32'h0F);
        cfg_write(ra(2, 'h14), 32'h05);
        cfg_read(ra(2, 'h10), 32'h0A, "R2 set then clear");
        req_chk(32'h6000, 1, 1, 8'd1, 3'b010, 1'b1, "R2 kept bit");
        req_chk(32'h6000, 1, 1, 8'd0, 3'b010, 1'b0, "R2 cleared bit");

        // R9: overlapping windows
        cfg_write(ra(3, 'h00), 32'h1800);
        cfg_write(ra(3, 'h04), 32'h18FF);
        cfg_write(ra(3, 'h10), 32'h08);
        cfg_write(EN_SET, 32'h8);
        req_chk(32'h1800, 1, 1, 8'd3, 0, 1'b1, "R9 inner grants");
        req_chk(32'h1900, 1, 1, 8'd3, 0, 1'b0, "R9 outer only");
        req_chk(32'h1800, 0, 1, 8'd0, 0, 1'b1, "R9 outer grants");

        // R3: disable windows
        cfg_write(EN_CLR, 32'h4);
        cfg_read(EN_SET, 32'h0B, "R3 clear one enable");
        req_chk(32'h6000, 1, 1, 8'd1, 3'b010, 1'b0, "R3 disabled miss strict");
        cfg_write(EN_CLR, 32'hFFFF_FFFF);
        cfg_read(EN_SET, 32'h0, "R3 clear all enables");
        req_chk(32'h6000, 1, 1, 8'd1, 3'b010, 1'b1, "R3 all disabled open");

        // R10: no event without a valid request
        @(negedge clk);
        req_valid = 1'b0; req_addr = 32'h0; req_cpu = 1'b1; req_id = 8'd1;
        cfg_write(EN_SET, 32'h1);
        @(negedge clk);
        #1;
        chk(deny_vld === 1'b0, "R10 idle no event", 32'(deny_vld), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule